// File: doc/BRIEF.md
# Vector Bitwise Logic Unit

This unit computes one bitwise operation across a whole vector register per accepted input. Each request carries three vector operands: the prior value of the destination, a first source and a second source. It also carries an immediate that has already been replicated across the vector, a 4-bit operation code and a width flag that selects 64-bit or full-width operation. Besides the plain two-source functions, the unit has merge operations that blend the sources into the destination's prior contents. It also has two immediate forms that take the destination's prior value as their other operand.

The result, an illegal-code flag and a valid strobe are registered. They appear one clock after the request is accepted. Instruction decode and immediate expansion happen upstream. The result does not depend on element size, because every bit position is computed on its own. In 64-bit mode the upper half of the result is cleared.

Top module: `vlu_top`

## Requirements
- R1: Code 0 returns src_a AND src_b, code 3 returns src_a OR src_b and code 6 returns src_a XOR src_b.
- R2: Code 1 (bit-clear) returns src_a AND NOT src_b. Code 5 returns src_a OR NOT src_b. Code 7 returns NOT src_a, and src_b has no effect on it.
- R3: Code 2 returns dst_in AND NOT imm, and code 4 returns dst_in OR imm. The sources have no effect on either code.
- R4: Code 9 (insert where set) returns dst_in XOR ((dst_in XOR src_a) AND src_b). Each result bit is src_a where src_b is 1 and dst_in where src_b is 0.
- R5: Code 10 (insert where clear) returns dst_in XOR ((dst_in XOR src_a) AND NOT src_b). Each result bit is src_a where src_b is 0 and dst_in where src_b is 1.
- R6: Code 8 (select) returns ((src_a XOR src_b) AND dst_in) XOR src_b. Each result bit is src_a where dst_in is 1 and src_b where dst_in is 0.
- R7: For a legal code with wide = 0, bits 127:64 of the result are zero. With wide = 1, all 128 bits hold the computed value.
- R8: Codes 11 to 15 are illegal. They return dst_in unchanged over all 128 bits, whatever the value of wide, and set illegal_out to 1. A legal code sets illegal_out to 0.
- R9: res_out and illegal_out for a request appear on the clock edge after the one that samples valid_in = 1. valid_out is valid_in delayed by one clock, so back-to-back requests give one result per cycle.
- R10: While valid_in is 0, res_out and illegal_out keep their last values whatever the other inputs do.
- R11: A synchronous active-high rst clears valid_out, res_out and illegal_out to zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Request strobe |
| op | input | 4 | Operation code (0 to 10 legal) |
| wide | input | 1 | 1 = 128-bit operation, 0 = 64-bit with upper half cleared |
| dst_in | input | 128 | Prior destination value |
| src_a | input | 128 | First source |
| src_b | input | 128 | Second source |
| imm | input | 128 | Replicated immediate |
| valid_out | output | 1 | Result strobe |
| res_out | output | 128 | Registered result |
| illegal_out | output | 1 | Registered illegal-code flag |

## Verification
Every result, the illegal flag and the valid strobe are due exactly one rising edge after the edge that samples the request. The bench drives inputs on the falling edge and compares the outputs on the next falling edge, so exactly one capturing edge lies between stimulus and check. Requests are streamed back to back, and each falling edge both checks the previous request and presents the next one. Hold behaviour is checked at the falling edge after the clock that sampled valid_in low. Reset clearing is checked at the falling edge after the reset clock.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

  typedef enum logic [3:0] {
    OP_AND     = 4'd0,
    OP_BIC     = 4'd1,
    OP_BIC_IMM = 4'd2,
    OP_OR      = 4'd3,
    OP_OR_IMM  = 4'd4,
    OP_ORN     = 4'd5,
    OP_XOR     = 4'd6,
    OP_NOT     = 4'd7,
    OP_SEL     = 4'd8,
    OP_INS_T   = 4'd9,
    OP_INS_F   = 4'd10
  } vlu_op_e;

  typedef struct packed {
    logic    legal;
    vlu_op_e kind;
  } vlu_dec_t;

endpackage

// File: rtl/vlu_op_decode.sv
module vlu_op_decode
  import vlu_pkg::*;
(
  input  logic [3:0] op_code,
  output vlu_dec_t   dec
);

  always_comb begin
    dec.kind  = vlu_op_e'(op_code);
    case (op_code)
      OP_AND, OP_BIC, OP_BIC_IMM, OP_OR, OP_OR_IMM, OP_ORN,
      OP_XOR, OP_NOT, OP_SEL, OP_INS_T, OP_INS_F: dec.legal = 1'b1;
      default:                                    dec.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/vlu_lane.sv
module vlu_lane
  import vlu_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  vlu_dec_t          dec,
  input  logic              clear,
  input  logic [LANE_W-1:0] d,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [LANE_W-1:0] imm,
  output logic [LANE_W-1:0] y
);

  logic [LANE_W-1:0] raw;

  always_comb begin
    raw = d;
    if (dec.legal) begin
      case (dec.kind)
        OP_AND:     raw = a & b;
        OP_BIC:     raw = a & ~b;
        OP_BIC_IMM: raw = d & ~imm;
        OP_OR:      raw = a | b;
        OP_OR_IMM:  raw = d | imm;
        OP_ORN:     raw = a | ~b;
        OP_XOR:     raw = a ^ b;
        OP_NOT:     raw = ~a;
        OP_SEL:     raw = ((a ^ b) & d) ^ b;
        OP_INS_T:   raw = d ^ ((d ^ a) & b);
        OP_INS_F:   raw = d ^ ((d ^ a) & ~b);
        default:    raw = d;
      endcase
    end
  end

  // clear only applies to legal codes; illegal codes pass d intact
  assign y = (clear && dec.legal) ? '0 : raw;

endmodule

// File: rtl/vlu_out_stage.sv
module vlu_out_stage #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic [VEC_W-1:0] res_d,
  input  logic             illegal_d,
  output logic             valid_q,
  output logic [VEC_W-1:0] res_q,
  output logic             illegal_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      res_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      valid_q <= valid_in;
      if (valid_in) begin
        res_q     <= res_d;
        illegal_q <= illegal_d;
      end
    end
  end

endmodule

// File: rtl/vlu_top.sv
module vlu_top
  import vlu_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic [3:0]       op,
  input  logic             wide,
  input  logic [VEC_W-1:0] dst_in,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] imm,
  output logic             valid_out,
  output logic [VEC_W-1:0] res_out,
  output logic             illegal_out
);

  localparam int NLANES     = VEC_W / LANE_W;
  localparam int HALF_LANES = NLANES / 2;

  vlu_dec_t          dec;
  logic [VEC_W-1:0]  res_comb;

  vlu_op_decode i_dec (
    .op_code (op),
    .dec     (dec)
  );

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic clr;
    if (g >= HALF_LANES) begin : g_hi
      assign clr = ~wide;
    end else begin : g_lo
      assign clr = 1'b0;
    end

    vlu_lane #(.LANE_W(LANE_W)) i_lane (
      .dec   (dec),
      .clear (clr),
      .d     (dst_in[g*LANE_W +: LANE_W]),
      .a     (src_a [g*LANE_W +: LANE_W]),
      .b     (src_b [g*LANE_W +: LANE_W]),
      .imm   (imm   [g*LANE_W +: LANE_W]),
      .y     (res_comb[g*LANE_W +: LANE_W])
    );
  end

  vlu_out_stage #(.VEC_W(VEC_W)) i_out (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .res_d     (res_comb),
    .illegal_d (~dec.legal),
    .valid_q   (valid_out),
    .res_q     (res_out),
    .illegal_q (illegal_out)
  );

endmodule

// File: rtl/vlu_checker.sv
module vlu_checker #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             valid_in,
  input logic [3:0]       op,
  input logic             wide,
  input logic [VEC_W-1:0] dst_in,
  input logic [VEC_W-1:0] src_a,
  input logic [VEC_W-1:0] src_b,
  input logic [VEC_W-1:0] imm,
  input logic             valid_out,
  input logic [VEC_W-1:0] res_out,
  input logic             illegal_out
);

  localparam int HALF = VEC_W / 2;

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) valid_in |=> valid_out); // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !valid_in |=> !valid_out); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !valid_in |=> ($stable(res_out) && $stable(illegal_out))); // R10
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) (valid_in && !wide && op <= 4'd10) |=> (res_out[VEC_W-1:HALF] == '0)); // R7
  AST_ILLEGAL_KEEP: assert property (@(posedge clk) disable iff (rst) (valid_in && op > 4'd10) |=> (illegal_out && res_out == $past(dst_in))); // R8
  AST_LEGAL_FLAG: assert property (@(posedge clk) disable iff (rst) (valid_in && op <= 4'd10) |=> !illegal_out); // R8
  AST_AND_LOW: assert property (@(posedge clk) disable iff (rst) (valid_in && op == 4'd0) |=> (res_out[HALF-1:0] == $past(src_a[HALF-1:0] & src_b[HALF-1:0]))); // R1
  AST_INS_T_LOW: assert property (@(posedge clk) disable iff (rst) (valid_in && op == 4'd9) |=> ((res_out[HALF-1:0] & $past(src_b[HALF-1:0])) == ($past(src_a[HALF-1:0]) & $past(src_b[HALF-1:0])))); // R4
  AST_SEL_LOW: assert property (@(posedge clk) disable iff (rst) (valid_in && op == 4'd8) |=> ((res_out[HALF-1:0] & ~$past(dst_in[HALF-1:0])) == ($past(src_b[HALF-1:0]) & ~$past(dst_in[HALF-1:0])))); // R6

endmodule

bind vlu_top vlu_checker #(.VEC_W(VEC_W)) i_chk (
  .clk(clk), .rst(rst), .valid_in(valid_in), .op(op), .wide(wide),
  .dst_in(dst_in), .src_a(src_a), .src_b(src_b), .imm(imm),
  .valid_out(valid_out), .res_out(res_out), .illegal_out(illegal_out)
);

// File: tb/test_vlu_top.sv
`timescale 1ns/1ps
module test_vlu_top;

  logic         clk = 1'b0;
  logic         rst;
  logic         valid_in;
  logic [3:0]   op;
  logic         wide;
  logic [127:0] dst_in, src_a, src_b, imm;
  logic         valid_out;
  logic [127:0] res_out;
  logic         illegal_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vlu_top i_vlu_top (
    .clk(clk), .rst(rst), .valid_in(valid_in), .op(op), .wide(wide),
    .dst_in(dst_in), .src_a(src_a), .src_b(src_b), .imm(imm),
    .valid_out(valid_out), .res_out(res_out), .illegal_out(illegal_out)
  );

  function automatic string req_of(input logic [3:0] c, input logic w);
    if (c > 4'd10) return "R8";
    if (!w) return "R7";
    case (c)
      4'd0, 4'd3, 4'd6: return "R1";
      4'd1, 4'd5, 4'd7: return "R2";
      4'd2, 4'd4:       return "R3";
      4'd9:             return "R4";
      4'd10:            return "R5";
      default:          return "R6";
    endcase
  endfunction

  function automatic logic [127:0] model(input logic [3:0] c, input logic w,
      input logic [127:0] d, input logic [127:0] a, input logic [127:0] b, input logic [127:0] m);
    logic [127:0] r;
    case (c)
      4'd0:  r = a & b;
      4'd1:  r = a & ~b;
      4'd2:  r = d & ~m;
      4'd3:  r = a | b;
      4'd4:  r = d | m;
      4'd5:  r = a | ~b;
      4'd6:  r = a ^ b;
      4'd7:  r = ~a;
      4'd8:  begin
        r = '0;
        for (int i = 0; i < 128; i++) r[i] = d[i] ? a[i] : b[i];
      end
      4'd9:  begin
        r = '0;
        for (int i = 0; i < 128; i++) r[i] = b[i] ? a[i] : d[i];
      end
      4'd10: begin
        r = '0;
        for (int i = 0; i < 128; i++) r[i] = b[i] ? d[i] : a[i];
      end
      default: return d;
    endcase
    if (!w) r[127:64] = '0;
    return r;
  endfunction

  function automatic logic [127:0] gen(input int n);
    logic [127:0] v;
    for (int i = 0; i < 4; i++)
      v[i*32 +: 32] = (32'h9E3779B9 * (n * 4 + i + 1)) ^ (32'h7F4A7C15 << ((n + i) % 13));
    return v;
  endfunction

  task automatic chk_bit(input string r, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", r, what, act, exp);
    end
  endtask

  task automatic chk_vec(input string r, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] e_res;
    logic         e_ill;
    logic [127:0] held;
    string        rq;

    rst = 1'b1; valid_in = 1'b1; op = 4'd3; wide = 1'b1;
    dst_in = '1; src_a = '1; src_b = '1; imm = '1;
    @(negedge clk);
    @(negedge clk);
    // R11: outputs clear under reset even with a request present
    chk_bit("R11", "valid_out in reset", valid_out, 1'b0);
    chk_vec("R11", "res_out in reset", res_out, '0);
    chk_bit("R11", "illegal_out in reset", illegal_out, 1'b0);
    rst = 1'b0; valid_in = 1'b0;
    @(negedge clk);

    // Exhaustive sweep over codes and widths, streamed back to back (R1..R9)
    for (int p = 0; p < 6; p++) begin
      for (int w = 0; w < 2; w++) begin
        for (int c = 0; c < 16; c++) begin
          logic [127:0] d, a, b, m;
          case (p)
            0: begin d = '0; a = '1; b = {32{4'hA}}; m = {32{4'h5}}; end
            1: begin d = '1; a = '0; b = {32{4'h5}}; m = {32{4'hA}}; end
            default: begin d = gen(p*4); a = gen(p*4+1); b = gen(p*4+2); m = gen(p*4+3); end
          endcase
          valid_in = 1'b1; op = 4'(c); wide = w[0];
          dst_in = d; src_a = a; src_b = b; imm = m;
          e_res = model(4'(c), w[0], d, a, b, m);
          e_ill = (c > 10);
          rq = req_of(4'(c), w[0]);
          @(negedge clk);
          chk_vec(rq, $sformatf("res op=%0d wide=%0d pat=%0d", c, w, p), res_out, e_res);
          chk_bit("R8", $sformatf("illegal op=%0d", c), illegal_out, e_ill);
          chk_bit("R9", "valid_out one cycle after request", valid_out, 1'b1);
        end
      end
    end

    // R10: idle cycles hold result while inputs change
    held = res_out;
    valid_in = 1'b0; op = 4'd0; wide = 1'b1; src_a = gen(99); src_b = gen(98); dst_in = gen(97);
    @(negedge clk);
    chk_bit("R9", "valid_out low after idle", valid_out, 1'b0);
    chk_vec("R10", "res_out held while idle", res_out, held);
    chk_bit("R10", "illegal_out held while idle", illegal_out, 1'b1);
    op = 4'd9;
    @(negedge clk);
    chk_vec("R10", "res_out still held", res_out, held);

    // R3: immediate forms ignore sources
    valid_in = 1'b1; op = 4'd4; wide = 1'b1; dst_in = gen(50); imm = gen(51); src_a = '1; src_b = '1;
    @(negedge clk);
    chk_vec("R3", "or-imm ignores sources", res_out, gen(50) | gen(51));
    op = 4'd2; src_a = '0; src_b = '0;
    @(negedge clk);
    chk_vec("R3", "bic-imm ignores sources", res_out, gen(50) & ~gen(51));
    // R2: NOT ignores src_b
    op = 4'd7; src_a = gen(52); src_b = gen(53);
    @(negedge clk);
    chk_vec("R2", "not ignores src_b", res_out, ~gen(52));

    // R11: reset mid-stream
    rst = 1'b1;
    @(negedge clk);
    chk_bit("R11", "valid_out after reset", valid_out, 1'b0);
    chk_vec("R11", "res_out after reset", res_out, '0);
    chk_bit("R11", "illegal_out after reset", illegal_out, 1'b0);
    rst = 1'b0; valid_in = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule